// File: doc/BRIEF.md
# Low-Rate Wake Countdown Timer

This block counts a 16-bit value down to zero and then raises a sticky wake event, so that a system held in a low-power state can be woken after a programmed interval. The count advances on tick enables taken from a 32768 Hz reference. The reference arrives as a single-cycle enable, `ref_tick`, in the block's only clock domain. A one-bit rate select chooses how the count advances. In fine mode it steps on every reference tick. In coarse mode it steps at 8 Hz, which an internal 12-bit divider of the reference enable produces.

Software controls the timer through three 16-bit word registers.

- **Reload register (offset 0x0).** There is no separate enable bit; this register both arms and disarms the timer. Writing a non-zero value copies that value into the count and starts the countdown at once. Writing zero stops the timer.
- **Rate register (offset 0x4).** Holds only the rate select bit.
- **Current-count register (offset 0x8).** Read-only; returns the live count.

Reads return combinationally, so `rd_data` follows `rd_addr` in the same cycle.

Top module: `wake_countdown_timer`

## Requirements
- R1: After reset, the reload register, the rate register and the current count all read 0, and `wake_evt` is 0.
- R2: A write of a non-zero value V to offset 0x0 makes offsets 0x0 and 0x8 both read V from the next cycle, and starts the countdown.
- R3: With rate bit 0 and the timer running, the count decreases by exactly 1 for each cycle in which `ref_tick` is 1. It does not change in cycles in which `ref_tick` is 0.
- R4: With rate bit 1, the count decreases by 1 once every 4096 `ref_tick` pulses. The divider phase restarts at each write to offset 0x0, so the first step comes on the 4096th pulse after that write.
- R5: When the count steps from 1 to 0, `wake_evt` rises on the same clock edge, and the timer stops. Further ticks leave the count at 0.
- R6: `wake_evt` stays at 1 until the next write to offset 0x0 of any value, which clears it.
- R7: A write of 0 to offset 0x0 stops the timer, sets the count to 0 and clears `wake_evt`. Later ticks then raise no event and change no count.
- R8: Offset 0x4 stores only bit 0 (0 = fine rate, 1 = coarse rate). Bits 15:1 always read 0 whatever is written to them.
- R9: Changing the rate bit while the timer runs does not reload or alter the count. The next step follows the newly selected rate.
- R10: When a write to offset 0x0 and a count step fall in the same cycle, the written value wins.
- R11: A read of any offset other than 0x0, 0x4 or 0x8 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and timer logic |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the register written |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Byte offset of the register read |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| wake_evt | output | 1 | Sticky wake event, set when the count expires |

## Verification
The assertions take for granted the following about the inputs:

- `ref_tick` and `wr_en` are clean synchronous levels, sampled only at rising clock edges.
- A write and a tick may share a cycle, and the rules give that case a defined result (R10).

The bench meets these conditions by changing every input only on the falling clock edge, holding each write for exactly one rising edge, and sampling outputs a little after the falling edge. It also deliberately drives one write coincident with a tick, so that the write-wins rule is exercised rather than avoided.

// File: rtl/wct_pkg.sv
package wct_pkg;
    // Register offsets; a bus decoder outside this block relies on them.
    localparam int OFS_RELOAD = 'h0;
    localparam int OFS_RATE   = 'h4;
    localparam int OFS_COUNT  = 'h8;

    typedef enum logic {
        RATE_FINE   = 1'b0,
        RATE_COARSE = 1'b1
    } rate_e;
endpackage

// File: rtl/wct_tick_div.sv
module wct_tick_div #(
    parameter int DIV_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic restart,
    output logic coarse_tick
);
    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        coarse_tick = ref_tick && (st_q.phase == {DIV_W{1'b1}});
        if (restart) begin
            st_d.phase = '0;
        end else if (ref_tick) begin
            st_d.phase = st_q.phase + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wct_regs.sv
module wct_regs
    import wct_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] reload_val,
    output rate_e             rate,
    output logic              reload_wr
);
    typedef struct packed {
        logic [DATA_W-1:0] reload;
        rate_e             rate;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       hit_reload, hit_rate;

    always_comb begin
        hit_reload = wr_en && (wr_addr == ADDR_W'(OFS_RELOAD));
        hit_rate   = wr_en && (wr_addr == ADDR_W'(OFS_RATE));
        st_d       = st_q;
        if (hit_reload) st_d.reload = wr_data;
        if (hit_rate)   st_d.rate   = rate_e'(wr_data[0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{reload: '0, rate: RATE_FINE};
        else        st_q <= st_d;
    end

    assign reload_val = st_q.reload;
    assign rate       = st_q.rate;
    assign reload_wr  = hit_reload;
endmodule

// File: rtl/wct_down_counter.sv
module wct_down_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              running,
    output logic              expired
);
    typedef struct packed {
        logic [DATA_W-1:0] count;
        logic              running;
        logic              expired;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.count   = load_val;
            st_d.running = (load_val != '0);
            st_d.expired = 1'b0;
        end else if (st_q.running && tick) begin
            st_d.count = st_q.count - DATA_W'(1);
            if (st_q.count == DATA_W'(1)) begin
                st_d.running = 1'b0;
                st_d.expired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign running = st_q.running;
    assign expired = st_q.expired;
endmodule

// File: rtl/wake_countdown_timer.sv
module wake_countdown_timer
    import wct_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wake_evt
);
    logic [DATA_W-1:0] reload_val;
    rate_e             rate;
    logic              reload_wr;
    logic              coarse_tick;
    logic              step_tick;
    logic [DATA_W-1:0] cur_count;
    logic              cnt_running;

    wct_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .reload_val (reload_val),
        .rate       (rate),
        .reload_wr  (reload_wr)
    );

    wct_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_tick    (ref_tick),
        .restart     (reload_wr),
        .coarse_tick (coarse_tick)
    );

    always_comb begin
        step_tick = (rate == RATE_COARSE) ? coarse_tick : ref_tick;
    end

    wct_down_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (step_tick),
        .load     (reload_wr),
        .load_val (wr_data),
        .count    (cur_count),
        .running  (cnt_running),
        .expired  (wake_evt)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_RELOAD))     rd_data = reload_val;
        else if (rd_addr == ADDR_W'(OFS_RATE))  rd_data = DATA_W'(rate);
        else if (rd_addr == ADDR_W'(OFS_COUNT)) rd_data = cur_count;
    end
endmodule

// File: rtl/wct_checker.sv
module wct_checker
    import wct_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              tick,
    input logic [DATA_W-1:0] count,
    input logic              running,
    input logic              wake_evt
);
    logic rl_wr;
    assign rl_wr = wr_en && (wr_addr == ADDR_W'(OFS_RELOAD));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rl_wr && (wr_data != '0) |=> (count == $past(wr_data)) && running);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rl_wr && running && tick |=> count == $past(count) - DATA_W'(1));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rl_wr && !tick |=> $stable(count));

    p_expired_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> (count == '0) && !running);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt && !rl_wr |=> wake_evt);

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rl_wr && (wr_data == '0) |=> !running && !wake_evt && (count == '0));

    p_rate_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(OFS_RATE)) |-> (rd_data[DATA_W-1:1] == '0));
endmodule

bind wake_countdown_timer wct_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .tick     (step_tick),
    .count    (cur_count),
    .running  (cnt_running),
    .wake_evt (wake_evt)
);

// File: tb/sim_wake_countdown_timer.sv
module sim_wake_countdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        wake_evt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    wake_countdown_timer u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wake_evt(wake_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        rd(4'h0, v); chk("R1 reload", v, 0);
        rd(4'h4, v); chk("R1 rate", v, 0);
        rd(4'h8, v); chk("R1 count", v, 0);
        chk("R1 wake_evt", int'(wake_evt), 0);
        rd(4'hC, v); chk("R11 unmapped", v, 0);
    endtask

    task automatic t_fine_countdown;
        int v;
        wr(4'h4, 16'h0000);
        wr(4'h0, 16'd10);
        rd(4'h8, v); chk("R2 count loaded", v, 10);
        rd(4'h0, v); chk("R2 reload readback", v, 10);
        idle(5);
        rd(4'h8, v); chk("R3 hold without tick", v, 10);
        run_ticks(3);
        rd(4'h8, v); chk("R3 step per tick", v, 7);
        run_ticks(6);
        rd(4'h8, v); chk("R3 count at 1", v, 1);
        chk("R5 no event before zero", int'(wake_evt), 0);
        run_ticks(1);
        rd(4'h8, v); chk("R5 count zero", v, 0);
        chk("R5 event raised", int'(wake_evt), 1);
        run_ticks(5);
        rd(4'h8, v); chk("R5 stopped at zero", v, 0);
        idle(3);
        chk("R6 event sticky", int'(wake_evt), 1);
    endtask

    task automatic t_zero_write;
        int v;
        wr(4'h0, 16'd0);
        chk("R6 R7 event cleared", int'(wake_evt), 0);
        rd(4'h8, v); chk("R7 count cleared", v, 0);
        run_ticks(20);
        rd(4'h8, v); chk("R7 stays stopped", v, 0);
        chk("R7 no event", int'(wake_evt), 0);
    endtask

    task automatic t_rate_bits;
        int v;
        wr(4'h4, 16'hFFFF);
        rd(4'h4, v); chk("R8 only bit0 kept", v, 1);
        wr(4'h4, 16'hFFFE);
        rd(4'h4, v); chk("R8 bit0 cleared", v, 0);
    endtask

    task automatic t_coarse;
        int v;
        wr(4'h4, 16'h0001);
        wr(4'h0, 16'd2);
        run_ticks(4095);
        rd(4'h8, v); chk("R4 no step before 4096", v, 2);
        run_ticks(1);
        rd(4'h8, v); chk("R4 step at 4096", v, 1);
        run_ticks(4096);
        rd(4'h8, v); chk("R4 R5 coarse expiry", v, 0);
        chk("R5 coarse event", int'(wake_evt), 1);
        wr(4'h0, 16'd5);
        chk("R6 nonzero write clears", int'(wake_evt), 0);
        rd(4'h8, v); chk("R2 reload after event", v, 5);
    endtask

    task automatic t_switch;
        int v;
        wr(4'h4, 16'h0000);
        wr(4'h0, 16'd100);
        run_ticks(10);
        rd(4'h8, v); chk("R9 fine before switch", v, 90);
        wr(4'h4, 16'h0001);
        rd(4'h8, v); chk("R9 no reload on switch", v, 90);
        run_ticks(4085);
        rd(4'h8, v); chk("R9 coarse wait", v, 90);
        run_ticks(1);
        rd(4'h8, v); chk("R9 coarse step", v, 89);
        wr(4'h4, 16'h0000);
        run_ticks(3);
        rd(4'h8, v); chk("R9 back to fine", v, 86);
    endtask

    task automatic t_collide;
        int v;
        wr(4'h0, 16'd50);
        @(negedge clk);
        ref_tick = 1'b1; wr_en = 1'b1; wr_addr = 4'h0; wr_data = 16'd20;
        @(negedge clk);
        ref_tick = 1'b0; wr_en = 1'b0;
        rd(4'h8, v); chk("R10 write wins over step", v, 20);
        wr(4'h0, 16'd0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_fine_countdown();
        t_zero_write();
        t_rate_bits();
        t_coarse();
        t_switch();
        t_collide();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule